// File: doc/BRIEF.md
# Page-Wrapping Word Address and Write Controller

This block sits behind a two-wire serial memory front end. It keeps the internal word address pointer and a one-page staging buffer for write data, and it holds a synthesizable byte array. The serial engine drives five things into it: a pulse that loads a new word address, a pulse per received data byte, a pulse per byte requested for reading, a pulse at the stop condition, and the level of the write-protect pin. It returns a registered read byte and a busy flag.

Data bytes received during a write are staged, not written straight away. Only the page offset of the pointer advances after each byte, so the pointer stays inside the current page. The stop pulse starts a self-timed write period of `WRITE_CYCLES` clock cycles. During that period the staged bytes are copied into the array, busy stays high and every request is ignored. Reads step the full pointer and wrap from the top of the array to address 0. The pointer keeps its value between transactions, so a current-address read continues from the last accessed byte plus one.

Top module: `page_wrap_store`

## Requirements
- R1: After synchronous reset, busy and byte_out are 0, the staging buffer is empty and the word address pointer is 0.
- R2: An accepted addr_load sets the pointer to addr_in. The next accepted byte_rd returns, one cycle later on byte_out, the array byte at that address.
- R3: Each accepted byte_wr stages byte_in at the page offset given by the pointer's low PAGE_W bits. It then increments only those low bits, wrapping from the last offset of the page to offset 0, and leaves the upper bits unchanged.
- R4: If more than one page of bytes is written in one burst, a later byte at the same offset replaces the earlier one. The array receives the last byte staged at each offset.
- R5: Only the offsets that received a byte in the burst are written to the array. The other bytes of the page keep their old values.
- R6: Each accepted byte_rd increments the full pointer, wrapping from 2**ADDR_W-1 to 0.
- R7: The pointer persists across transactions. A byte_rd with no preceding addr_load returns the byte that follows the last byte written or read.
- R8: A stop_commit with staged bytes and wr_protect low raises busy in the next cycle. Busy stays high for exactly WRITE_CYCLES cycles. The staged bytes are in the array once busy falls, and the staging buffer is then empty.
- R9: While busy is high, addr_load, byte_wr, byte_rd and stop_commit have no effect: the pointer, the staging buffer, the array and byte_out do not change.
- R10: A stop_commit while wr_protect is high leaves the array unchanged and does not raise busy. The staged bytes are still discarded, but while wr_protect is high byte_wr still stages bytes.
- R11: A stop_commit with an empty staging buffer does not raise busy. This is the case after a dummy write that only loads an address, or after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load addr_in into the pointer and start a new write burst (highest priority) |
| addr_in | input | ADDR_W | Word address to load |
| byte_wr | input | 1 | Stage byte_in at the current page offset |
| byte_in | input | DATA_W | Data byte to stage |
| byte_rd | input | 1 | Read the byte at the pointer and increment the pointer |
| stop_commit | input | 1 | Stop condition: start the timed write of the staged bytes (lowest priority) |
| wr_protect | input | 1 | Write protect level; high blocks the commit |
| byte_out | output | DATA_W | Registered read data |
| busy | output | 1 | High during the self-timed write period |

## Verification
The embedded properties check on every cycle that a data byte never moves the pointer to another page, that a read steps the pointer by exactly one, that nothing changes while busy, that busy never outlasts the timer window and that the array is written only while busy. Protected and empty commits are checked for never raising busy. Which bytes end up in the array is shown only by the bench scenarios: the last byte wins after an overflowing burst, only the received offsets change after a partial burst, the pointer wraps across the whole array on reads and current-address reads continue from the last access. The bench fills every page from a mid-page start, then reads the whole array back against an arithmetic model.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // One decoded request per cycle; the decoder in the top applies priority.
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_COMMIT = 3'd4
  } op_e;

endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [PAGE_W-1:0] OFF_ONE  = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] off_nxt;

  // write stepping: only the page offset moves
  assign off_nxt = addr_q[PAGE_W-1:0] + OFF_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  addr_q <= load_addr;
        OP_WRITE: addr_q <= {addr_q[ADDR_W-1:PAGE_W], off_nxt};
        OP_READ:  addr_q <= addr_q + ADDR_ONE;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  assign addr = addr_q;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    op == OP_WRITE |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])); // R3

  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    op == OP_READ |=> addr_q == $past(addr_q) + ADDR_ONE); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    op == OP_NONE |=> $stable(addr_q)); // R9

endmodule

// File: rtl/pgw_stage_buf.sv
module pgw_stage_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_fire,
  input  logic [PAGE_W-1:0]        wr_off,
  input  logic [ADDR_W-PAGE_W-1:0] wr_tag,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clear,
  input  logic [PAGE_W-1:0]        sel_off,
  output logic [DATA_W-1:0]        sel_byte,
  output logic                     sel_valid,
  output logic                     any_valid,
  output logic [ADDR_W-PAGE_W-1:0] tag
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [PAGE_BYTES-1:0] vld;
  logic [DATA_W-1:0]     bytes [PAGE_BYTES];
  logic [TAG_W-1:0]      tag_q;

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    logic              hit;

    assign hit = wr_fire && (wr_off == PAGE_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (clear) begin
        v_q <= 1'b0;
      end else if (hit) begin
        v_q <= 1'b1;
      end
    end

    // data slots carry no reset; the valid bit guards them
    always_ff @(posedge clk) begin
      if (hit) begin
        d_q <= wr_data;
      end
    end

    assign vld[s]   = v_q;
    assign bytes[s] = d_q;
  end

  // page row is taken from the pointer at the first byte of a burst
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (wr_fire && (vld == '0)) begin
      tag_q <= wr_tag;
    end
  end

  assign sel_byte  = bytes[sel_off];
  assign sel_valid = vld[sel_off];
  assign any_valid = |vld;
  assign tag       = tag_q;

  AST_STAGE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr_fire && !clear |=> any_valid); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> !any_valid); // R8

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq #(
  parameter int WRITE_CYCLES = 16,
  parameter int PAGE_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              step_en,
  output logic [PAGE_W-1:0] step_off
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  // the window must leave room to copy a full page
  localparam int WIN   = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES;
  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_ONE;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy     = busy_q;
  assign done     = last;
  assign step_en  = busy_q && (cnt_q < CNT_PAGE);
  assign step_off = cnt_q[PAGE_W-1:0];

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q <= CNT_LAST); // R8

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    start && !busy_q |=> busy_q && cnt_q == '0); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> cnt_q == '0); // R8

endmodule

// File: rtl/pgw_byte_array.sv
module pgw_byte_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata_q)); // R9

endmodule

// File: rtl/page_wrap_store.sv
module page_wrap_store
  import pgw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 3,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              byte_rd,
  input  logic              stop_commit,
  input  logic              wr_protect,
  output logic [DATA_W-1:0] byte_out,
  output logic              busy
);

  localparam int TAG_W = ADDR_W - PAGE_W;

  op_e               op;
  logic [ADDR_W-1:0] ptr;
  logic              seq_busy;
  logic              seq_done;
  logic              step_en;
  logic [PAGE_W-1:0] step_off;
  logic [DATA_W-1:0] stage_byte;
  logic              stage_valid;
  logic              stage_any;
  logic [TAG_W-1:0]  stage_tag;
  logic              commit_go;
  logic              stage_clear;
  logic              mem_we;

  // request priority: load, write, read, stop; nothing while busy
  always_comb begin
    if (seq_busy)         op = OP_NONE;
    else if (addr_load)   op = OP_LOAD;
    else if (byte_wr)     op = OP_WRITE;
    else if (byte_rd)     op = OP_READ;
    else if (stop_commit) op = OP_COMMIT;
    else                  op = OP_NONE;
  end

  assign commit_go   = (op == OP_COMMIT) && stage_any && !wr_protect;
  assign stage_clear = (op == OP_LOAD) || ((op == OP_COMMIT) && wr_protect) || seq_done;
  assign mem_we      = step_en && stage_valid;

  pgw_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .load_addr (addr_in),
    .addr      (ptr)
  );

  pgw_stage_buf #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (op == OP_WRITE),
    .wr_off    (ptr[PAGE_W-1:0]),
    .wr_tag    (ptr[ADDR_W-1:PAGE_W]),
    .wr_data   (byte_in),
    .clear     (stage_clear),
    .sel_off   (step_off),
    .sel_byte  (stage_byte),
    .sel_valid (stage_valid),
    .any_valid (stage_any),
    .tag       (stage_tag)
  );

  pgw_commit_seq #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .PAGE_W       (PAGE_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (commit_go),
    .busy     (seq_busy),
    .done     (seq_done),
    .step_en  (step_en),
    .step_off (step_off)
  );

  pgw_byte_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr ({stage_tag, step_off}),
    .wdata (stage_byte),
    .re    (op == OP_READ),
    .raddr (ptr),
    .rdata (byte_out)
  );

  assign busy = seq_busy;

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R8

  AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COMMIT) && wr_protect |=> !busy); // R10

  AST_EMPTY_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COMMIT) && !stage_any |=> !busy); // R11

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr) && $stable(byte_out)); // R9

endmodule

// File: tb/page_wrap_store_tb.sv
module page_wrap_store_tb;

  localparam int AW    = 8;
  localparam int PW    = 3;
  localparam int DW    = 8;
  localparam int WC    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int PB    = 1 << PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          byte_wr = 1'b0;
  logic [DW-1:0] byte_in = '0;
  logic          byte_rd = 1'b0;
  logic          stop_commit = 1'b0;
  logic          wr_protect = 1'b0;
  logic [DW-1:0] byte_out;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  // bench model
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] sb [PB];
  bit            sv [PB];
  int            ctr = 0;
  int            tag = 0;

  always #5 clk = ~clk;

  page_wrap_store #(
    .ADDR_W (AW), .PAGE_W (PW), .DATA_W (DW), .WRITE_CYCLES (WC)
  ) u_dut (
    .clk (clk), .rst (rst), .addr_load (addr_load), .addr_in (addr_in),
    .byte_wr (byte_wr), .byte_in (byte_in), .byte_rd (byte_rd),
    .stop_commit (stop_commit), .wr_protect (wr_protect),
    .byte_out (byte_out), .busy (busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit staged_any();
    for (int i = 0; i < PB; i++) if (sv[i]) return 1;
    return 0;
  endfunction

  // every task is entered at a falling edge and leaves at one
  task automatic do_load(input int a);
    addr_load = 1'b1; addr_in = AW'(a);
    @(negedge clk);
    addr_load = 1'b0;
    ctr = a;
    for (int i = 0; i < PB; i++) sv[i] = 0;
  endtask

  task automatic do_write(input int d);
    byte_wr = 1'b1; byte_in = DW'(d);
    @(negedge clk);
    byte_wr = 1'b0;
    if (!staged_any()) tag = ctr / PB;
    sb[ctr % PB] = DW'(d);
    sv[ctr % PB] = 1;
    ctr = (ctr / PB) * PB + ((ctr + 1) % PB);
  endtask

  task automatic do_read(input string req);
    byte_rd = 1'b1;
    @(negedge clk);
    byte_rd = 1'b0;
    chk(req, 32'(byte_out), 32'(model[ctr]));
    ctr = (ctr + 1) % DEPTH;
  endtask

  // stop pulse, then count the cycles busy is seen high
  task automatic do_commit(input bit exp_busy, input string req);
    int n;
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(req, 32'(n), exp_busy ? 32'(WC) : 32'd0);
    if (exp_busy) begin
      for (int i = 0; i < PB; i++) if (sv[i]) model[tag * PB + i] = sb[i];
    end
    for (int i = 0; i < PB; i++) sv[i] = 0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < PB; i++) sv[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at the ports
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 byte_out", 32'(byte_out), 32'd0);
    // R1: pointer starts at 0, so a write with no load lands at address 0
    do_write(8'hA5);
    do_commit(1, "R8 busy length");
    do_load(0);
    do_read("R1 pointer at zero");

    // R3 R8: fill every page from a mid-page start, wrapping inside the page
    for (int p = 0; p < DEPTH / PB; p++) begin
      do_load(p * PB + (p % PB));
      for (int i = 0; i < PB; i++) do_write((p * 37 + i * 11 + 3) & 8'hFF);
      chk("R3 pointer back at start offset", 32'(ctr), 32'(p * PB + (p % PB)));
      do_commit(1, "R8 busy length fill");
    end

    // R2 R6: whole array from 0, then past the top wraps to 0
    do_load(0);
    for (int i = 0; i < DEPTH + 2; i++) do_read("R6 sequential read with wrap");
    do_load(8'hFE);
    do_read("R2 loaded address");
    do_read("R6 top byte");
    do_read("R6 wrap to zero");

    // R5: partial burst changes only three offsets
    do_load(8'h45);
    do_write(8'h11); do_write(8'h22); do_write(8'h33);
    do_commit(1, "R8 busy length partial");
    do_load(8'h40);
    for (int i = 0; i < PB; i++) do_read("R5 partial page");

    // R4: eleven bytes into an eight-byte page, last byte wins
    do_load(8'h12);
    for (int i = 0; i < 11; i++) do_write(8'h80 + i);
    chk("R4 model offset 2 overwritten", 32'(sb[2]), 32'h88);
    do_commit(1, "R8 busy length overflow");
    do_load(8'h10);
    for (int i = 0; i < PB; i++) do_read("R4 overflow page");

    // R7: current-address reads after write bursts
    do_load(8'h58);
    do_write(8'h5A); do_write(8'h5B);
    do_commit(1, "R8 busy length");
    do_read("R7 read follows last write");
    do_load(8'h5E);
    do_write(8'h61); do_write(8'h62); do_write(8'h63);
    do_commit(1, "R8 busy length");
    do_read("R7 read follows page-wrapped write");
    do_read("R7 read follows last read");

    // R9: requests during the write window are ignored
    do_load(8'h20);
    do_write(8'hC3);
    stop_commit = 1'b1;
    @(negedge clk);
    stop_commit = 1'b0;
    chk("R8 busy raised", 32'(busy), 32'd1);
    held = byte_out;
    addr_load = 1'b1; addr_in = 8'h80;
    byte_wr = 1'b1; byte_in = 8'hEE;
    byte_rd = 1'b1; stop_commit = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 byte_out held while busy", 32'(byte_out), 32'(held));
    end
    addr_load = 1'b0; byte_wr = 1'b0; byte_rd = 1'b0; stop_commit = 1'b0;
    while (busy === 1'b1) @(negedge clk);
    model[8'h20] = 8'hC3;
    for (int i = 0; i < PB; i++) sv[i] = 0;
    chk("R9 no second window", 32'(busy), 32'd0);
    do_read("R9 pointer unchanged by load while busy");
    do_load(8'h80);
    do_read("R9 array unchanged by write while busy");

    // R10: protected commit
    wr_protect = 1'b1;
    do_load(8'h30);
    do_write(8'h01); do_write(8'h02); do_write(8'h03); do_write(8'h04);
    do_commit(0, "R10 no busy when protected");
    wr_protect = 1'b0;
    do_commit(0, "R10 staged bytes discarded");
    do_load(8'h30);
    for (int i = 0; i < 4; i++) do_read("R10 array untouched");

    // R11: stop after a dummy write and after a read
    do_load(8'h70);
    do_commit(0, "R11 no busy after address only");
    do_read("R11 read after dummy write");
    do_commit(0, "R11 no busy after read");

    finish_run();
  end

endmodule